// File: doc/BRIEF.md
# Card Clock Generator with FIFO Flow Gating

This block derives the serial clock for a memory-card host port from the system master clock. A 9-bit divisor N gives a card clock period of N + 2 master cycles, so odd and even ratios are both available. The high phase takes the lower half of the period. An optional power-save stage multiplies the period by a further (2^P) + 1, where P is a 3-bit field.

When a data transfer is running, the clock can be held low for flow control. In a read transfer it is held while the receive FIFO is full, when read gating is enabled. In a write transfer it is held while the transmit FIFO is empty, when write gating is enabled. The hold only lengthens the low phase, so the card never sees a shortened high pulse.

Configuration is written as one 32-bit word through a write strobe. Writes are dropped while the write-protect input is high. The block gives the card clock itself, plus a one-cycle strobe for each rising edge and each falling edge. Neighbouring command and data logic can use these strobes as clock enables.

Top module: `cardclk_gen`

## Requirements
- R1: The card clock period is N + 2 master cycles. N is 9 bits wide: its LSB is config bit 16 and its upper eight bits are config bits 7:0.
- R2: Each period starts with a high phase of floor(ratio/2) master cycles, followed by a low phase with the rest of the ratio.
- R3: While power-save is enabled and P (config bits 10:8) is nonzero, the ratio is (N + 2) * ((2^P) + 1).
- R4: A power-save enable has no effect while P is zero.
- R5: Read gating is enabled by config bit 11. While it is set, a transfer is active, the direction input is 1 (read) and the FIFO is full, the card clock stays low. The next rising edge comes in the first master cycle after the full flag drops, provided the low phase has already run its length.
- R6: Write gating is enabled by config bit 12. While it is set, a transfer is active, the direction input is 0 (write) and the FIFO is empty, the card clock stays low. It resumes in the same way as in R5.
- R7: A configuration write is ignored while the write-protect input is high.
- R8: A new configuration takes effect at the next rising edge. The period in progress keeps its old length.
- R9: After reset the ratio is 2, and power-save and both gating features are off.
- R10: rise_stb is high only in the first master cycle in which card_clk is high. fall_stb is high only in the first master cycle in which card_clk is low.
- R11: A hold never cuts short a high phase. The FIFO flags have no effect while no transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| wprot | input | 1 | Write protect; blocks cfg_wr when high |
| pws_en | input | 1 | Power-save enable |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_dir | input | 1 | Transfer direction: 1 read, 0 write |
| fifo_full | input | 1 | Receive FIFO full |
| fifo_empty | input | 1 | Transmit FIFO empty |
| card_clk | output | 1 | Card clock |
| rise_stb | output | 1 | One-cycle strobe on each rising edge |
| fall_stb | output | 1 | One-cycle strobe on each falling edge |

## Verification
A configuration word is registered on the edge after the write. It is then latched into the phase counter at the next rising edge, so the bench measures a new ratio only from the second rising edge after the write. The one exception is the R8 check, which counts the period already in progress while the write lands. Flow inputs act on the edge where a rise is due. After a held low phase ends, rise_stb and card_clk are therefore expected at the very next falling-edge sample, and the bench checks for exactly one cycle. All samples are taken on the falling master edge, and phase lengths are counted in whole master cycles between the two strobes.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
   localparam int CFG_W    = 32;
   localparam int POS_PWS  = 8;
   localparam int POS_RDG  = 11;
   localparam int POS_WRG  = 12;
   localparam int POS_ODD  = 16;
   localparam int PWS_MAXW = 3;
   localparam int DIV_MAXW = 8;

   typedef enum logic {
      DIR_WRITE = 1'b0,
      DIR_READ  = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/cc_cfg_reg.sv
module cc_cfg_reg
   import cardclk_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int PWS_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   input  logic             wprot,
   output logic [DIV_W:0]   divisor,
   output logic [PWS_W-1:0] pwsdiv,
   output logic             rd_gate,
   output logic             wr_gate
);
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   generate
      if (DIV_W < 1 || DIV_W > DIV_MAXW) begin : g_bad_div
         $error("cc_cfg_reg: DIV_W out of range");
      end
      if (PWS_W < 1 || PWS_W > PWS_MAXW) begin : g_bad_pws
         $error("cc_cfg_reg: PWS_W out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         divisor <= '0;
         pwsdiv  <= '0;
         rd_gate <= 1'b0;
         wr_gate <= 1'b0;
      end else if (wr && !wprot) begin
         divisor <= {wdata[DIV_W-1:0], wdata[POS_ODD]};
         pwsdiv  <= wdata[POS_PWS +: PWS_W];
         rd_gate <= wdata[POS_RDG];
         wr_gate <= wdata[POS_WRG];
      end
   end

   AST_WPROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wprot) |=> ($stable(divisor) && $stable(pwsdiv) && $stable(rd_gate) && $stable(wr_gate))); // R7
   AST_ODD_IS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wprot) |=> (divisor[0] == $past(wdata[POS_ODD]))); // R1
endmodule

// File: rtl/cc_ratio.sv
module cc_ratio #(
   parameter int DIV_W   = 8,
   parameter int PWS_W   = 3,
   parameter bit HAS_PWS = 1'b1,
   parameter int RATIO_W = DIV_W + 2 + (1 << PWS_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DIV_W:0]     divisor,
   input  logic [PWS_W-1:0]   pwsdiv,
   input  logic               pws_en,
   output logic [RATIO_W-1:0] hi_len,
   output logic [RATIO_W-1:0] lo_len
);
   localparam int BASE_W = DIV_W + 2;
   localparam int MULT_W = 1 << PWS_W;

   logic [BASE_W-1:0]  base;
   logic [MULT_W-1:0]  mult;
   logic [RATIO_W-1:0] total;

   assign base = BASE_W'(divisor) + BASE_W'(2);

   generate
      if (HAS_PWS) begin : g_pws
         logic pws_live;
         assign pws_live = pws_en && (pwsdiv != '0);
         assign mult = pws_live ? ((MULT_W'(1) << pwsdiv) + MULT_W'(1)) : MULT_W'(1);
      end else begin : g_nopws
         logic unused_pws;
         assign unused_pws = pws_en ^ (^pwsdiv);
         assign mult = MULT_W'(1);
      end
   endgenerate

   assign total  = RATIO_W'(base) * RATIO_W'(mult);
   assign hi_len = total >> 1;
   assign lo_len = total - hi_len;

   AST_PWS_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (pwsdiv == '0) |-> ((hi_len + lo_len) == RATIO_W'(divisor) + RATIO_W'(2))); // R4
   AST_LOW_NOT_SHORTER: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_len >= hi_len) && (lo_len - hi_len <= RATIO_W'(1))); // R2
endmodule

// File: rtl/cc_flow_gate.sv
module cc_flow_gate
   import cardclk_pkg::*;
(
   input  logic xfer_active,
   input  logic xfer_dir,
   input  logic fifo_full,
   input  logic fifo_empty,
   input  logic rd_gate,
   input  logic wr_gate,
   output logic hold
);
   logic rd_block;
   logic wr_block;

   always_comb begin
      rd_block = rd_gate && (xfer_dir == DIR_READ)  && fifo_full;
      wr_block = wr_gate && (xfer_dir == DIR_WRITE) && fifo_empty;
      hold     = xfer_active && (rd_block || wr_block);
   end
endmodule

// File: rtl/cc_phase.sv
module cc_phase #(
   parameter int RATIO_W = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] new_hi,
   input  logic [RATIO_W-1:0] new_lo,
   input  logic               hold,
   output logic               clk_q,
   output logic               rise,
   output logic               fall
);
   logic [RATIO_W-1:0] cnt;
   logic [RATIO_W-1:0] cur_hi;
   logic [RATIO_W-1:0] cur_lo;
   logic               hi_done;
   logic               lo_done;

   assign hi_done = (cnt == cur_hi - RATIO_W'(1));
   assign lo_done = (cnt >= cur_lo - RATIO_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q  <= 1'b0;
         cnt    <= '0;
         cur_hi <= RATIO_W'(1);
         cur_lo <= RATIO_W'(1);
         rise   <= 1'b0;
         fall   <= 1'b0;
      end else begin
         rise <= 1'b0;
         fall <= 1'b0;
         if (clk_q) begin
            if (hi_done) begin
               clk_q <= 1'b0;
               cnt   <= '0;
               fall  <= 1'b1;
            end else begin
               cnt <= cnt + RATIO_W'(1);
            end
         end else if (!lo_done) begin
            cnt <= cnt + RATIO_W'(1);
         end else if (!hold) begin
            clk_q  <= 1'b1;
            cnt    <= '0;
            rise   <= 1'b1;
            cur_hi <= new_hi;
            cur_lo <= new_lo;
         end
      end
   end

   AST_HOLD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !clk_q) |=> !clk_q); // R5
   AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |-> ($stable(cur_hi) && $stable(cur_lo))); // R8
   AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall)); // R10
   AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> (clk_q && !$past(clk_q))); // R10
   AST_FALL_AFTER_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_q && !hi_done) |=> clk_q); // R11
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
   import cardclk_pkg::*;
#(
   parameter int DIV_W   = 8,
   parameter int PWS_W   = 3,
   parameter bit HAS_PWS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             wprot,
   input  logic             pws_en,
   input  logic             xfer_active,
   input  logic             xfer_dir,
   input  logic             fifo_full,
   input  logic             fifo_empty,
   output logic             card_clk,
   output logic             rise_stb,
   output logic             fall_stb
);
   localparam int RATIO_W = DIV_W + 2 + (1 << PWS_W);

   logic [DIV_W:0]     divisor;
   logic [PWS_W-1:0]   pwsdiv;
   logic               rd_gate;
   logic               wr_gate;
   logic [RATIO_W-1:0] hi_len;
   logic [RATIO_W-1:0] lo_len;
   logic               hold;

   cc_cfg_reg #(.DIV_W(DIV_W), .PWS_W(PWS_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata), .wprot(wprot),
      .divisor(divisor), .pwsdiv(pwsdiv), .rd_gate(rd_gate), .wr_gate(wr_gate)
   );

   cc_ratio #(.DIV_W(DIV_W), .PWS_W(PWS_W), .HAS_PWS(HAS_PWS), .RATIO_W(RATIO_W)) u_ratio (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .pwsdiv(pwsdiv), .pws_en(pws_en),
      .hi_len(hi_len), .lo_len(lo_len)
   );

   cc_flow_gate u_gate (
      .xfer_active(xfer_active), .xfer_dir(xfer_dir), .fifo_full(fifo_full),
      .fifo_empty(fifo_empty), .rd_gate(rd_gate), .wr_gate(wr_gate), .hold(hold)
   );

   cc_phase #(.RATIO_W(RATIO_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .new_hi(hi_len), .new_lo(lo_len), .hold(hold),
      .clk_q(card_clk), .rise(rise_stb), .fall(fall_stb)
   );

   AST_IDLE_FLAGS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active |-> !hold); // R11
endmodule

// File: tb/cardclk_gen_test.sv
module cardclk_gen_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        wprot = 1'b0;
   logic        pws_en = 1'b0;
   logic        xfer_active = 1'b0;
   logic        xfer_dir = 1'b0;
   logic        fifo_full = 1'b0;
   logic        fifo_empty = 1'b0;
   logic        card_clk;
   logic        rise_stb;
   logic        fall_stb;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   cardclk_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .wprot(wprot),
      .pws_en(pws_en), .xfer_active(xfer_active), .xfer_dir(xfer_dir),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty),
      .card_clk(card_clk), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wcfg(input int n, input int p, input bit rd, input bit wr);
      logic [31:0] d;
      d = '0;
      d[7:0]  = 8'(n >> 1);
      d[10:8] = 3'(p);
      d[11]   = rd;
      d[12]   = wr;
      d[16]   = n[0];
      @(negedge clk);
      cfg_wdata = d;
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic wait_rise();
      do @(negedge clk); while (!rise_stb);
   endtask

   // measure one period from a rising edge; also counts strobe misplacements
   task automatic measure(output int hi, output int lo, output int stb_err);
      wait_rise();
      hi = 0; lo = 0; stb_err = 0;
      while (card_clk) begin
         if ((hi == 0) != rise_stb) stb_err++;
         if (fall_stb) stb_err++;
         hi++;
         @(negedge clk);
      end
      while (!card_clk) begin
         if ((lo == 0) != fall_stb) stb_err++;
         if (rise_stb) stb_err++;
         lo++;
         @(negedge clk);
      end
   endtask

   task automatic expect_period(input string req, input int n, input int p, input bit pw);
      int r, hi, lo, se;
      r = (n + 2) * ((pw && p != 0) ? ((1 << p) + 1) : 1);
      wait_rise();
      wait_rise();
      measure(hi, lo, se);
      check(req, hi, r / 2);
      check(req, lo, r - r / 2);
      check({req, " R10 strobes"}, se, 0);
   endtask

   initial begin
      int hi, lo, se, per, bad;
      // R9: reset state
      #(CLK_PERIOD * 3);
      @(negedge clk);
      check("R9 reset card_clk", int'(card_clk), 0);
      check("R9 reset strobes", int'(rise_stb | fall_stb), 0);
      // R9: features off after reset, even with flags asserted
      xfer_active = 1'b1; xfer_dir = 1'b1; fifo_full = 1'b1; fifo_empty = 1'b1; pws_en = 1'b1;
      rst_n = 1'b1;
      measure(hi, lo, se);
      check("R9 ratio2 hi", hi, 1);
      check("R9 ratio2 lo", lo, 1);
      xfer_active = 1'b0; fifo_full = 1'b0; fifo_empty = 1'b0; pws_en = 1'b0;

      // R1/R2: sweep of divisor values, odd and even ratios
      for (int n = 0; n < 24; n++) begin
         wcfg(n, 0, 1'b0, 1'b0);
         expect_period("R1 R2 sweep", n, 0, 1'b0);
      end
      wcfg(511, 0, 1'b0, 1'b0);
      expect_period("R1 max divisor", 511, 0, 1'b0);
      wcfg(256, 0, 1'b0, 1'b0);
      expect_period("R1 upper bits only", 256, 0, 1'b0);

      // R3: power-save multiplier sweep
      pws_en = 1'b1;
      for (int p = 1; p < 8; p++) begin
         wcfg(1, p, 1'b0, 1'b0);
         expect_period("R3 power save", 1, p, 1'b1);
      end
      // R4: P = 0 with power-save enabled
      wcfg(3, 0, 1'b0, 1'b0);
      expect_period("R4 pws ignored", 3, 0, 1'b1);
      // R3: field present but enable low
      pws_en = 1'b0;
      wcfg(2, 4, 1'b0, 1'b0);
      expect_period("R3 pws disabled", 2, 4, 1'b0);

      // R7: write protect
      wcfg(5, 0, 1'b0, 1'b0);
      wprot = 1'b1;
      wcfg(20, 0, 1'b0, 1'b0);
      expect_period("R7 write protect", 5, 0, 1'b0);
      wprot = 1'b0;

      // R8: change in mid-period keeps current length
      wcfg(18, 0, 1'b0, 1'b0);
      wait_rise(); wait_rise();
      cfg_wdata = '0; cfg_wdata[7:0] = 8'd1; cfg_wr = 1'b1; // N = 2
      per = 0;
      do begin
         per++;
         @(negedge clk);
         if (per == 1) cfg_wr = 1'b0;
      end while (!rise_stb);
      check("R8 old period kept", per, 20);
      measure(hi, lo, se);
      check("R8 new period hi", hi, 2);
      check("R8 new period lo", lo, 2);

      // R5: read gating holds clock low while FIFO full
      wcfg(2, 0, 1'b1, 1'b0);
      wait_rise(); wait_rise();
      xfer_active = 1'b1; xfer_dir = 1'b1; fifo_full = 1'b1;
      repeat (10) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         if (card_clk || rise_stb) bad++;
         @(negedge clk);
      end
      check("R5 held low", bad, 0);
      fifo_full = 1'b0;
      per = 0;
      do begin per++; @(negedge clk); end while (!rise_stb && per < 50);
      check("R5 resume latency", per, 1);
      // R5: read gating does not act on a write transfer
      xfer_dir = 1'b0; fifo_full = 1'b1;
      expect_period("R5 wrong direction", 2, 0, 1'b0);
      fifo_full = 1'b0; xfer_active = 1'b0;

      // R6: write gating holds clock low while FIFO empty
      wcfg(4, 0, 1'b0, 1'b1);
      wait_rise(); wait_rise();
      xfer_active = 1'b1; xfer_dir = 1'b0; fifo_empty = 1'b1;
      repeat (12) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         if (card_clk || rise_stb) bad++;
         @(negedge clk);
      end
      check("R6 held low", bad, 0);
      fifo_empty = 1'b0;
      per = 0;
      do begin per++; @(negedge clk); end while (!rise_stb && per < 50);
      check("R6 resume latency", per, 1);
      xfer_active = 1'b0;

      // R11: hold raised during high phase does not cut it short
      wcfg(10, 0, 1'b1, 1'b0);
      wait_rise(); wait_rise();
      xfer_active = 1'b1; xfer_dir = 1'b1; fifo_full = 1'b1;
      hi = 0;
      while (card_clk) begin hi++; @(negedge clk); end
      check("R11 full high phase", hi, 6);
      lo = 0;
      repeat (30) begin
         if (!card_clk) lo++;
         @(negedge clk);
      end
      check("R11 low stretched", lo, 30);
      fifo_full = 1'b0;
      // R11: flags inert without an active transfer
      xfer_active = 1'b0; fifo_full = 1'b1; fifo_empty = 1'b1;
      expect_period("R11 idle flags", 10, 0, 1'b0);
      fifo_full = 1'b0; fifo_empty = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule